// File: doc/BRIEF.md
# Strip Hit Latch, Serial Shifter, Monitor Mux and Fold Trigger

This block is the digital front end for a group of detector strips whose hits have already been discriminated. When a latch strobe arrives, it takes a snapshot of all strip levels and holds it. A load command then moves the snapshot into a shift register. Each shift pulse sends one bit out on the serial output, most significant strip first, and takes one bit in from the serial input. Because of this, several boards can be wired output-to-input in a chain that feeds one readout module.

The block also routes one strip, chosen by a select input, to a monitor output so that an external scaler can count that strip's noise rate. It raises a local trigger when enough strips are hit at the same time. The trigger level can be set from 1 to 4 strips.

All inputs are sampled on one system clock. The shift clock reaches the block as a single-cycle enable pulse, and its rate can go up to the data transfer rate of the chain.

Top module: `strip_frontend`

## Requirements
- R1: While reset is high and in the first cycle after it, `ser_out`, `mon_out`, `l1_trig` and `busy` are all 0.
- R2: A `capture` pulse with `busy` low stores the `strips` value present at that clock edge as the held pattern.
- R3: A `load` pulse copies the held pattern into the shift register. From the next cycle `ser_out` shows strip 31. After each `shift_en` edge it shows the next lower strip, down to strip 0.
- R4: Each `shift_en` edge takes `ser_in` into the bottom of the shift register. After 32 shifts following a load, `ser_out` gives the upstream bits back in the order they arrived.
- R5: `busy` goes to 1 in the cycle after `load`. It goes back to 0 in the cycle after the 32nd `shift_en` that follows that load.
- R6: A `capture` pulse while `busy` is 1 is ignored, and the held pattern stays as it was.
- R7: A `load` while `busy` is 1 restarts the sequence from the held pattern with a fresh count of 32. If `load` and `shift_en` come in the same cycle, `load` wins.
- R8: `mon_out` equals `strips[mon_sel]` as sampled at the previous clock edge, where `mon_sel` is a 5-bit strip index.
- R9: `l1_trig` is 1 when the number of 1 bits in `strips` at the previous edge is at least the trigger level set by `fold_thr`.
- R10: A `fold_thr` of 0 works as a level of 1, and values from 5 to 7 work as a level of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strips | input | 32 | Live digitized strip hits |
| capture | input | 1 | Latch strobe, one-cycle pulse |
| load | input | 1 | Copy held pattern into shift register |
| shift_en | input | 1 | Shift clock enable, one pulse per bit |
| ser_in | input | 1 | Serial data from the upstream board |
| mon_sel | input | 5 | Strip index routed to the monitor output |
| fold_thr | input | 3 | Trigger level in hit strips |
| ser_out | output | 1 | Serial data toward the downstream board |
| mon_out | output | 1 | Selected strip, registered |
| l1_trig | output | 1 | Local multiplicity trigger, registered |
| busy | output | 1 | Shift-out sequence in progress |

## Verification
`mon_out` and `l1_trig` pass through one register each, so they are due one edge after their inputs. The bench drives inputs on a falling edge and reads the outputs on the following falling edge. A capture, load or shift takes effect at the rising edge in between, so `ser_out` and `busy` are read in that same half-cycle window, one edge after the pulse. To check the serial stream, the bench reads `ser_out` before each shift pulse and compares it with a bit index it counts down itself. An ignored capture is checked by loading and shifting the whole pattern out again after the strobe.

// File: rtl/strip_fe_pkg.sv
package strip_fe_pkg;
  localparam int FOLD_MIN = 1;
  localparam int FOLD_MAX = 4;

  // Clamp the programmed fold level into the legal range.
  function automatic int unsigned eff_level(input logic [2:0] thr);
    if (thr < 3'(FOLD_MIN)) return FOLD_MIN;
    if (thr > 3'(FOLD_MAX)) return FOLD_MAX;
    return int'(thr);
  endfunction
endpackage

// File: rtl/strip_fe_shifter.sv
module strip_fe_shifter #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strips,
  input  logic         capture,
  input  logic         load,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         busy,
  output logic [N-1:0] held
);
  localparam int CNT_W = $clog2(N + 1);

  logic [N-1:0]     latch_q;
  logic [N-1:0]     shreg_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      shreg_q <= '0;
      left_q  <= '0;
    end else begin
      if (capture && left_q == '0) latch_q <= strips;
      if (load) begin
        shreg_q <= latch_q;
        left_q  <= CNT_W'(N);
      end else if (shift_en) begin
        shreg_q <= {shreg_q[N-2:0], ser_in};
        if (left_q != '0) left_q <= left_q - 1'b1;
      end
    end
  end

  assign ser_out = shreg_q[N-1];
  assign busy    = (left_q != '0);
  assign held    = latch_q;
endmodule

// File: rtl/strip_fe_monmux.sv
module strip_fe_monmux #(
  parameter int N     = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     strips,
  input  logic [SEL_W-1:0] sel,
  output logic             mon
);
  always_ff @(posedge clk) begin
    if (rst) mon <= 1'b0;
    else     mon <= strips[sel];
  end
endmodule

// File: rtl/strip_fe_fold.sv
module strip_fe_fold
  import strip_fe_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strips,
  input  logic [2:0]   thr,
  output logic         trig
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] hits;

  always_comb begin
    hits = '0;
    for (int i = 0; i < N; i++) hits = hits + CW'(strips[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= (32'(hits) >= eff_level(thr));
  end
endmodule

// File: rtl/strip_frontend.sv
module strip_frontend #(
  parameter int N     = 32,
  parameter int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     strips,
  input  logic             capture,
  input  logic             load,
  input  logic             shift_en,
  input  logic             ser_in,
  input  logic [SEL_W-1:0] mon_sel,
  input  logic [2:0]       fold_thr,
  output logic             ser_out,
  output logic             mon_out,
  output logic             l1_trig,
  output logic             busy
);
  logic [N-1:0] held;

  strip_fe_shifter #(.N(N)) u_shift (
    .clk(clk), .rst(rst), .strips(strips), .capture(capture), .load(load),
    .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out), .busy(busy),
    .held(held)
  );

  strip_fe_monmux #(.N(N), .SEL_W(SEL_W)) u_mon (
    .clk(clk), .rst(rst), .strips(strips), .sel(mon_sel), .mon(mon_out)
  );

  strip_fe_fold #(.N(N)) u_fold (
    .clk(clk), .rst(rst), .strips(strips), .thr(fold_thr), .trig(l1_trig)
  );
endmodule

// File: rtl/strip_frontend_chk.sv
module strip_frontend_chk #(
  parameter int N     = 32,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     strips,
  input logic             capture,
  input logic             load,
  input logic             shift_en,
  input logic [SEL_W-1:0] mon_sel,
  input logic             mon_out,
  input logic             l1_trig,
  input logic             busy,
  input logic [N-1:0]     held
);
  a_r5_load_sets_busy: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);

  a_r5_busy_ends_on_shift: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(shift_en) && !$past(load)));

  a_r2_capture_when_idle: assert property (@(posedge clk) disable iff (rst)
    (capture && !busy) |=> (held == $past(strips)));

  a_r6_capture_blocked: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(held));

  a_r8_monitor_select: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (mon_out == $past(strips[mon_sel])));

  a_r10_full_fold_fires: assert property (@(posedge clk) disable iff (rst)
    ($countones(strips) >= 4) |=> l1_trig);

  a_r9_no_hits_no_trig: assert property (@(posedge clk) disable iff (rst)
    ($countones(strips) == 0) |=> !l1_trig);
endmodule

bind strip_frontend strip_frontend_chk #(.N(N), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .strips(strips), .capture(capture), .load(load),
  .shift_en(shift_en), .mon_sel(mon_sel), .mon_out(mon_out),
  .l1_trig(l1_trig), .busy(busy), .held(held)
);

// File: tb/tb_strip_frontend.sv
module tb_strip_frontend;
  localparam int  N = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  strips = '0;
  logic          capture = 1'b0, load = 1'b0, shift_en = 1'b0, ser_in = 1'b0;
  logic [4:0]    mon_sel = '0;
  logic [2:0]    fold_thr = 3'd1;
  logic          ser_out, mon_out, l1_trig, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strip_frontend dut (
    .clk(clk), .rst(rst), .strips(strips), .capture(capture), .load(load),
    .shift_en(shift_en), .ser_in(ser_in), .mon_sel(mon_sel),
    .fold_thr(fold_thr), .ser_out(ser_out), .mon_out(mon_out),
    .l1_trig(l1_trig), .busy(busy)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive control inputs for one clock, then sample at the next falling edge.
  task automatic pulse(input logic c, input logic l, input logic s,
                       input logic si);
    @(negedge clk);
    capture = c; load = l; shift_en = s; ser_in = si;
    @(negedge clk);
    capture = 1'b0; load = 1'b0; shift_en = 1'b0; ser_in = 1'b0;
  endtask

  // Shift out one full word and check it; shift in 'upstream'.
  task automatic drain(input string req, input logic [N-1:0] exp,
                       input logic [N-1:0] upstream);
    int bad = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ser_out !== exp[i]) bad++;
      pulse(1'b0, 1'b0, 1'b1, upstream[i]);
    end
    check(req, 64'(bad), 64'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    strips = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 during reset", {60'd0, ser_out, mon_out, l1_trig, busy}, 64'd0);
    rst = 1'b0;
    strips = '0;
    @(negedge clk);
    check("R1 after reset", {60'd0, ser_out, mon_out, l1_trig, busy}, 64'd0);
  endtask

  task automatic t_capture_shift();
    logic [N-1:0] pat = 32'hA5C3_0F81;
    strips = pat;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    strips = 32'h1234_5678;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 busy after load", 64'(busy), 64'd1);
    check("R3 first bit is strip 31", 64'(ser_out), 64'(pat[N-1]));
    drain("R2 R3 captured word MSB first", pat, '0);
    check("R5 busy clear after 32 shifts", 64'(busy), 64'd0);
  endtask

  task automatic t_chain();
    logic [N-1:0] a = 32'hDEAD_BEEF;
    logic [N-1:0] b = 32'h0F0F_3C96;
    strips = a;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = N - 1; i >= 1; i--) pulse(1'b0, 1'b0, 1'b1, b[i]);
    check("R5 busy still high after 31 shifts", 64'(busy), 64'd1);
    pulse(1'b0, 1'b0, 1'b1, b[0]);
    check("R5 busy low after 32nd shift", 64'(busy), 64'd0);
    drain("R4 upstream word passes through", b, '0);
  endtask

  task automatic t_capture_blocked();
    logic [N-1:0] a = 32'h8000_0001;
    strips = a;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    strips = 32'h7FFF_FFFE;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    drain("R3 word during blocked capture", a, '0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    drain("R6 capture while busy ignored", a, '0);
  endtask

  task automatic t_reload();
    logic [N-1:0] a = 32'hC001_D00D;
    strips = a;
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) pulse(1'b0, 1'b0, 1'b1, 1'b1);
    pulse(1'b0, 1'b1, 1'b1, 1'b1);
    check("R7 load wins over shift, busy held", 64'(busy), 64'd1);
    for (int i = N - 1; i >= 1; i--) begin
      if (ser_out !== a[i]) check("R7 restarted word bit", 64'(ser_out), 64'(a[i]));
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
    end
    check("R7 fresh count of 32 after reload", 64'(busy), 64'd1);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 sequence ends after 32 shifts", 64'(busy), 64'd0);
  endtask

  task automatic t_monitor();
    int bad = 0;
    logic [N-1:0] pat = 32'h9B3D_4E61;
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      strips = pat; mon_sel = 5'(s);
      @(negedge clk);
      strips = ~pat;
      if (mon_out !== pat[s]) bad++;
    end
    check("R8 monitor follows select, one cycle", 64'(bad), 64'd0);
    @(negedge clk);
    mon_sel = 5'd7;
    strips = 32'h0000_0080;
    @(negedge clk);
    check("R8 single strip on channel 7", 64'(mon_out), 64'd1);
  endtask

  task automatic t_fold();
    logic [N-1:0] pats [6] = '{32'h0, 32'h0001_0000, 32'h8000_0001,
                                32'h0101_0100, 32'h1111_0000, 32'hF800_0000};
    for (int t = 0; t < 8; t++) begin
      for (int p = 0; p < 6; p++) begin
        int lvl = (t == 0) ? 1 : (t > 4) ? 4 : t;
        @(negedge clk);
        fold_thr = 3'(t); strips = pats[p];
        @(negedge clk);
        strips = '0;
        check((t == 0 || t > 4) ? "R10 clamped level" : "R9 fold trigger",
              64'(l1_trig), 64'(p >= lvl));
      end
    end
  endtask

  initial begin
    t_reset();
    t_capture_shift();
    t_chain();
    t_capture_blocked();
    t_reload();
    t_monitor();
    t_fold();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule